// File: doc/BRIEF.md
# Page Burst Program Sequencer

This block is a host-side master for a parallel NOR flash bus. It programs one full page of 256 sixteen-bit words with the flash's large-page buffered programming command set. A client gives a page-aligned block address with a one-cycle start strobe, then streams the 256 words over a valid/ready handshake. The sequencer opens the command set, sends the load command, the 256 data writes and the confirm write, waits for the device to report ready, and closes the command set again.

Each bus write lasts one clock. During it `bus_we` is high and `bus_addr`/`bus_data` hold the cycle's word. The client stream sets the pace of the data phase: a word that is not offered stalls the bus. When the device stays busy longer than a runtime-programmable limit, the sequencer issues the abort command instead of the exit pair and flags an error. A start request whose address is not page aligned is refused at once and touches nothing on the bus.

Top module: `pgburst_seq`

## Requirements
- R1: After an accepted start, the first three bus writes fall on consecutive cycles and are (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0x38). The first of them is on the bus two clock edges after the edge that sampled `start`.
- R2: The fourth write is the load command, 0x33, written to the latched block address.
- R3: Writes 5 to 260 carry the 256 stream words in arrival order. Their address low 8 bits are offsets 0x00 to 0xFF, strictly increasing. Their upper address bits equal those of the block address.
- R4: `in_ready` is high only during the data phase. A data write appears on the bus only in the cycle after an `in_valid`/`in_ready` handshake, so a missing word stalls the bus.
- R5: The 261st write is the confirm, 0x29 to the block address at offset 0x00. This makes 258 writes from the load command through the confirm.
- R6: After the confirm, the sequencer samples `bus_ready` each cycle. Once it is high, two writes follow, data 0x90 and then 0x00. `done` pulses for one cycle together with the 0x00 write.
- R7: If `bus_ready` is low on `tmo_limit`+1 consecutive wait cycles, the sequencer skips the exit pair. It writes (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0xF0), and `err` pulses together with the last of these. `done` stays low.
- R8: A start with any of the low 8 address bits nonzero makes `err` pulse in the cycle after the sampling edge. No bus write follows and `busy` stays low.
- R9: `busy` is high from the cycle after an accepted start until the cycle after `done` or `err`. A `start` that arrives while busy has no effect.
- R10: During and right after reset, `bus_we`, `busy`, `in_ready`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to program a page |
| blk_addr | input | ADDR_W | Word address of the page; low PAGE_W bits must be zero |
| tmo_limit | input | TMO_W | Ready-wait limit in cycles, minus one |
| in_data | input | 16 | Stream word |
| in_valid | input | 1 | Stream word valid |
| in_ready | output | 1 | Sequencer accepts a stream word |
| bus_addr | output | ADDR_W | Flash word address for the current write |
| bus_data | output | 16 | Flash data for the current write |
| bus_we | output | 1 | Write cycle strobe, one clock per write |
| bus_ready | input | 1 | Flash ready/busy status, high when ready |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Page programmed and command set closed |
| err | output | 1 | Misaligned request or ready-wait timeout |

## Verification
The bench builds the block with its default parameters: a 24-bit address, 8 offset bits (a full 256-word page) and a 16-bit timeout. With these, every run produces the exact 258-write burst, and both upper-address extremes, all zeros and all ones, are reachable. Because the ready-wait limit is a port, the bench can sit one cycle either side of the timeout and can also use a zero limit. The stall patterns on the stream force the data phase to pause at different offsets without changing the sequence the bus receives.

// File: rtl/pgburst_pkg.sv
package pgburst_pkg;

  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ENTER,
    ST_SETUP,
    ST_DATA,
    ST_CONF,
    ST_WAIT,
    ST_EXIT,
    ST_ABORT
  } pg_state_e;

  localparam logic [WORD_W-1:0] CMD_OPEN   = 16'h0038;
  localparam logic [WORD_W-1:0] CMD_LOAD   = 16'h0033;
  localparam logic [WORD_W-1:0] CMD_CONF   = 16'h0029;
  localparam logic [WORD_W-1:0] CMD_CLOSE0 = 16'h0090;
  localparam logic [WORD_W-1:0] CMD_CLOSE1 = 16'h0000;
  localparam logic [WORD_W-1:0] CMD_ABORT  = 16'h00F0;

  // Address of step idx in a three-write unlocked command.
  function automatic logic [11:0] unlock_addr(input logic [1:0] idx);
    return (idx == 2'd1) ? 12'h2AA : 12'h555;
  endfunction

  // Data of step idx; the third step carries the command code.
  function automatic logic [WORD_W-1:0] unlock_data(input logic [1:0] idx,
                                                    input logic [WORD_W-1:0] code);
    case (idx)
      2'd0:    return 16'h00AA;
      2'd1:    return 16'h0055;
      default: return code;
    endcase
  endfunction

  // Data of step idx in the two-write close pair.
  function automatic logic [WORD_W-1:0] close_data(input logic [1:0] idx);
    return (idx == 2'd0) ? CMD_CLOSE0 : CMD_CLOSE1;
  endfunction

endpackage

// File: rtl/pgburst_tmo.sv
module pgburst_tmo #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);

  logic [TMO_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == limit);

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |-> (cnt < limit)); // R7

endmodule

// File: rtl/pgburst_busdrv.sv
module pgburst_busdrv #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_we   <= 1'b0;
      bus_addr <= '0;
      bus_data <= '0;
    end else begin
      bus_we <= wr_req;
      if (wr_req) begin
        bus_addr <= wr_addr;
        bus_data <= wr_data;
      end
    end
  end

endmodule

// File: rtl/pgburst_seq.sv
module pgburst_seq
  import pgburst_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int PAGE_W = 8,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] blk_addr,
  input  logic [TMO_W-1:0]  tmo_limit,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [WORD_W-1:0] bus_data,
  output logic              bus_we,
  input  logic              bus_ready,
  output logic              busy,
  output logic              done,
  output logic              err
);

  localparam logic [PAGE_W-1:0] LAST_OFF = {PAGE_W{1'b1}};

  pg_state_e         st, st_n;
  logic [1:0]        idx, idx_n;
  logic [PAGE_W-1:0] off, off_n;
  logic [ADDR_W-1:0] ba_q, ba_n;
  logic              done_n, err_n;

  logic              wr_req;
  logic [ADDR_W-1:0] wr_addr;
  logic [WORD_W-1:0] wr_data;
  logic              tmr_clr, tmr_en, tmr_exp;

  // Named events for the checks below.
  logic aligned;
  logic data_fire;
  logic start_ok;
  logic start_bad;

  assign aligned   = (blk_addr[PAGE_W-1:0] == '0);
  assign in_ready  = (st == ST_DATA);
  assign data_fire = in_ready && in_valid;
  assign start_ok  = (st == ST_IDLE) && start && aligned;
  assign start_bad = (st == ST_IDLE) && start && !aligned;
  assign busy      = (st != ST_IDLE);

  function automatic logic [ADDR_W-1:0] page_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [PAGE_W-1:0] o);
    return {base[ADDR_W-1:PAGE_W], o};
  endfunction

  function automatic logic [ADDR_W-1:0] cmd_addr(input logic [1:0] i);
    return ADDR_W'(unlock_addr(i));
  endfunction

  always_comb begin
    st_n    = st;
    idx_n   = idx;
    off_n   = off;
    ba_n    = ba_q;
    done_n  = 1'b0;
    err_n   = 1'b0;
    wr_req  = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    tmr_clr = 1'b0;
    tmr_en  = 1'b0;
    case (st)
      ST_IDLE: begin
        tmr_clr = 1'b1;
        if (start_ok) begin
          ba_n  = blk_addr;
          idx_n = 2'd0;
          st_n  = ST_ENTER;
        end else if (start_bad) begin
          err_n = 1'b1;
        end
      end
      ST_ENTER: begin
        wr_req  = 1'b1;
        wr_addr = cmd_addr(idx);
        wr_data = unlock_data(idx, CMD_OPEN);
        if (idx == 2'd2) begin
          idx_n = 2'd0;
          st_n  = ST_SETUP;
        end else begin
          idx_n = idx + 2'd1;
        end
      end
      ST_SETUP: begin
        wr_req  = 1'b1;
        wr_addr = ba_q;
        wr_data = CMD_LOAD;
        off_n   = '0;
        st_n    = ST_DATA;
      end
      ST_DATA: begin
        if (data_fire) begin
          wr_req  = 1'b1;
          wr_addr = page_addr(ba_q, off);
          wr_data = in_data;
          if (off == LAST_OFF) st_n = ST_CONF;
          else                 off_n = off + 1'b1;
        end
      end
      ST_CONF: begin
        wr_req  = 1'b1;
        wr_addr = page_addr(ba_q, '0);
        wr_data = CMD_CONF;
        tmr_clr = 1'b1;
        st_n    = ST_WAIT;
      end
      ST_WAIT: begin
        if (bus_ready) begin
          idx_n = 2'd0;
          st_n  = ST_EXIT;
        end else if (tmr_exp) begin
          idx_n = 2'd0;
          st_n  = ST_ABORT;
        end else begin
          tmr_en = 1'b1;
        end
      end
      ST_EXIT: begin
        wr_req  = 1'b1;
        wr_addr = ba_q;
        wr_data = close_data(idx);
        if (idx == 2'd1) begin
          done_n = 1'b1;
          st_n   = ST_IDLE;
        end else begin
          idx_n = 2'd1;
        end
      end
      ST_ABORT: begin
        wr_req  = 1'b1;
        wr_addr = cmd_addr(idx);
        wr_data = unlock_data(idx, CMD_ABORT);
        if (idx == 2'd2) begin
          err_n = 1'b1;
          st_n  = ST_IDLE;
        end else begin
          idx_n = idx + 2'd1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      idx  <= '0;
      off  <= '0;
      ba_q <= '0;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      st   <= st_n;
      idx  <= idx_n;
      off  <= off_n;
      ba_q <= ba_n;
      done <= done_n;
      err  <= err_n;
    end
  end

  pgburst_tmo #(.TMO_W(TMO_W)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (tmr_clr),
    .en      (tmr_en),
    .limit   (tmo_limit),
    .expired (tmr_exp)
  );

  pgburst_busdrv #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_bus (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_req   (wr_req),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_data (bus_data)
  );

  AST_FIRST_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> ##1 (bus_we && bus_data == 16'h00AA)); // R1

  AST_NO_WRITE_WITHOUT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA && !in_valid) |=> !bus_we); // R4

  AST_OFFSET_HOLDS_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA && !in_valid) |=> $stable(off)); // R3

  AST_PAGE_HIGH_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    data_fire |=> (bus_addr[ADDR_W-1:PAGE_W] == ba_q[ADDR_W-1:PAGE_W])); // R3

  AST_EXIT_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && bus_ready) |=> ##1 (bus_we && bus_data == 16'h0090)); // R6

  AST_ABORT_AFTER_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && !bus_ready && tmr_exp) |=> ##1 (bus_we && bus_data == 16'h00AA)); // R7

  AST_DONE_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err)); // R6

  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    start_bad |=> (err && !bus_we && !busy)); // R8

  AST_READY_ONLY_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (busy && !done && !err)); // R4

endmodule

// File: tb/tb_pgburst_seq.sv
`timescale 1ns/1ps
module tb_pgburst_seq;

  localparam int ADDR_W = 24;
  localparam int TMO_W  = 16;
  localparam int NLOG   = 300;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] blk_addr = '0;
  logic [TMO_W-1:0]  tmo_limit = '0;
  logic [15:0]       in_data = '0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [ADDR_W-1:0] bus_addr;
  logic [15:0]       bus_data;
  logic              bus_we;
  logic              bus_ready = 1'b1;
  logic              busy, done, err;

  always #2.5 clk = ~clk;

  pgburst_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_addr(blk_addr),
    .tmo_limit(tmo_limit), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_we(bus_we), .bus_ready(bus_ready), .busy(busy), .done(done), .err(err)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Bus monitor and flash ready model.
  logic [ADDR_W-1:0] log_a [NLOG];
  logic [15:0]       log_d [NLOG];
  int                log_c [NLOG];
  int cyc = 0, wc = 0, done_cnt = 0, err_cnt = 0, done_wc = 0, err_wc = 0, err_cyc = 0;
  int bad_stall = 0, bad_ready = 0, busy_cycles = 0;
  int ready_low = 0, low_left = 0;
  logic prev_fire = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (busy) busy_cycles++;
    if (low_left > 0) begin
      low_left--;
      if (low_left == 0) bus_ready = 1'b1;
    end
    if (bus_we) begin
      if (wc >= 4 && wc <= 259 && !prev_fire) bad_stall++;
      if (wc < NLOG) begin
        log_a[wc] = bus_addr; log_d[wc] = bus_data; log_c[wc] = cyc;
      end
      wc++;
      if (wc == 261 && ready_low > 0) begin
        bus_ready = 1'b0;
        low_left  = ready_low;
      end
    end
    if (done) begin done_cnt++; done_wc = wc; end
    if (err)  begin err_cnt++;  err_wc = wc; err_cyc = cyc; end
    if (in_ready && (wc < 4 || wc > 259)) bad_ready++;
    prev_fire = in_ready && in_valid;
  end

  function automatic logic [15:0] word_of(input logic [15:0] seed, input int i);
    return seed ^ (16'(i) * 16'h0F1D) ^ 16'(i);
  endfunction

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  typedef struct packed {
    logic [23:0] ba;
    logic [15:0] seed;
    logic [7:0]  stall;
    logic [15:0] lowlen;
    logic [15:0] tmo;
    logic [1:0]  outcome; // 0 done, 1 timeout, 2 reject
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{24'h000000, 16'h1234, 8'd0, 16'd0,  16'd5,   2'd0},
    '{24'hFFFF00, 16'hA5A5, 8'd3, 16'd5,  16'd5,   2'd0},
    '{24'h123400, 16'h0F0F, 8'd2, 16'd6,  16'd5,   2'd1},
    '{24'h000080, 16'h0000, 8'd0, 16'd0,  16'd5,   2'd2},
    '{24'h800001, 16'h0000, 8'd0, 16'd0,  16'd5,   2'd2},
    '{24'h7F0000, 16'hC3C3, 8'd7, 16'd20, 16'd100, 2'd0}
  };

  task automatic feed(input logic [15:0] seed, input int stall, input bit poke);
    int i = 0;
    int k = 0;
    while (i < 256 && k < 5000) begin
      @(posedge clk); #1;
      k++;
      start = (poke && k == 10);
      blk_addr = (poke && k == 10) ? 24'h00AB00 : blk_addr;
      if (in_ready && (stall == 0 || (k % stall) != 0)) begin
        in_valid = 1'b1;
        in_data  = word_of(seed, i);
        i++;
      end else begin
        in_valid = 1'b0;
      end
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
    start    = 1'b0;
  endtask

  task automatic run_op(input vec_t v, input bit poke, input string tag);
    int c0;
    int w;
    int bad;
    logic [23:0] ba;
    ba = v.ba;
    wc = 0; done_cnt = 0; err_cnt = 0; bad_stall = 0; bad_ready = 0; busy_cycles = 0;
    ready_low = int'(v.lowlen);
    tmo_limit = v.tmo;
    @(posedge clk); #1;
    start = 1'b1; blk_addr = ba; c0 = cyc;
    @(posedge clk); #1;
    start = 1'b0;
    if (v.outcome != 2'd2) feed(v.seed, int'(v.stall), poke);
    w = 0;
    while (done_cnt + err_cnt == 0 && w < 2000) begin @(posedge clk); w++; end
    repeat (4) @(posedge clk);
    #1;
    if (v.outcome == 2'd2) begin
      chk(wc == 0, "R8", {tag, " no bus write on reject"}, wc, 0);
      chk(err_cnt == 1 && err_cyc == c0 + 2, "R8", {tag, " err cycle"}, err_cyc, c0 + 2);
      chk(busy_cycles == 0, "R8", {tag, " busy stays low"}, busy_cycles, 0);
      return;
    end
    chk(log_a[0] == 24'h555 && log_d[0] == 16'hAA && log_a[1] == 24'h2AA && log_d[1] == 16'h55
        && log_a[2] == 24'h555 && log_d[2] == 16'h38, "R1", {tag, " open sequence"},
        {log_a[2][7:0], log_d[2][7:0]}, 32'h5538);
    chk(log_c[0] == c0 + 3 && log_c[1] == c0 + 4 && log_c[2] == c0 + 5, "R1",
        {tag, " open timing"}, log_c[0], c0 + 3);
    chk(log_a[3] == ba && log_d[3] == 16'h33, "R2", {tag, " load command"}, log_d[3], 16'h33);
    bad = 0;
    for (int i = 0; i < 256; i++)
      if (log_a[4+i] != (ba | 24'(i)) || log_d[4+i] != word_of(v.seed, i)) bad++;
    chk(bad == 0, "R3", {tag, " data words/offsets"}, bad, 0);
    chk(bad_stall == 0 && bad_ready == 0, "R4", {tag, " stall discipline"},
        bad_stall + bad_ready, 0);
    chk(log_a[260] == ba && log_d[260] == 16'h29, "R5", {tag, " confirm"}, log_d[260], 16'h29);
    if (v.outcome == 2'd0) begin
      chk(wc == 263, "R6", {tag, " total writes"}, wc, 263);
      chk(log_d[261] == 16'h90 && log_d[262] == 16'h00, "R6", {tag, " close pair"},
          {log_d[261], log_d[262]}, 32'h00900000);
      chk(done_cnt == 1 && err_cnt == 0 && done_wc == 263, "R6", {tag, " done with last write"},
          done_wc, 263);
    end else begin
      chk(wc == 264, "R7", {tag, " total writes"}, wc, 264);
      chk(log_a[261] == 24'h555 && log_d[261] == 16'hAA && log_a[262] == 24'h2AA &&
          log_d[262] == 16'h55 && log_a[263] == 24'h555 && log_d[263] == 16'hF0,
          "R7", {tag, " abort sequence"}, log_d[263], 16'hF0);
      chk(err_cnt == 1 && done_cnt == 0 && err_wc == 264, "R7", {tag, " err with last write"},
          err_wc, 264);
    end
    chk(!busy, "R9", {tag, " busy released"}, busy, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!bus_we && !busy && !in_ready && !done && !err, "R10", "outputs in reset",
        {bus_we, busy, in_ready, done, err}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(!bus_we && !busy && !in_ready && !done && !err, "R10", "outputs after reset",
        {bus_we, busy, in_ready, done, err}, 0);

    for (int n = 0; n < 6; n++) run_op(VECS[n], 1'b0, $sformatf("vec%0d", n));

    // R9: a start during the data phase must not disturb the page.
    run_op('{24'h345600, 16'h5AA5, 8'd4, 16'd3, 16'd10, 2'd0}, 1'b1, "restart_ignored");
    // R7: zero limit, one busy cycle aborts; zero busy cycles completes.
    run_op('{24'h010100, 16'h7777, 8'd0, 16'd1, 16'd0, 2'd1}, 1'b0, "tmo0_abort");
    run_op('{24'h020200, 16'h8888, 8'd0, 16'd0, 16'd0, 2'd0}, 1'b0, "tmo0_done");

    // R9: busy rises one cycle after the sampling edge.
    @(posedge clk); #1;
    tmo_limit = 16'd5; ready_low = 0; wc = 0; done_cnt = 0; err_cnt = 0;
    start = 1'b1; blk_addr = 24'h050500;
    @(posedge clk); #1;
    start = 1'b0;
    chk(busy, "R9", "busy after accepted start", busy, 1);
    feed(16'h1111, 0, 1'b0);
    while (done_cnt == 0) @(posedge clk);
    @(posedge clk); #1;
    chk(!busy, "R9", "busy low after done", busy, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule